// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synthesizable behavioural model of a synchronous pipelined SRAM. Reads and writes can follow each other in any mix on every enabled clock, and no idle cycle is needed between them. The block registers address and control on the rising edge. A read returns its word from an output register. A write is posted, and its data is taken later, in the same bus slot a read would use. Because both kinds of operation have the same slot timing, the direction of the data bus can change from one cycle to the next.

The block has three chip selects, active-low byte-lane write selects and a clock enable that freezes the whole pipeline. A load/advance control either starts a new access at an external address or continues a four-beat burst from the last loaded address. The burst runs in linear or interleaved order. A small internal array stands in for the storage. The data bus is split into an input and an output, and a flag tells when the block would drive the bus.

Top module: `zt_burst_sram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pipeline is emptied, any burst is ended, `rd_oe` goes to 0 and `rdata` goes to zero.
- R2: A read loaded at enabled edge n sets `rd_oe` to 1 and presents the word on `rdata` after enabled edge n+2. Both hold for one slot.
- R3: A write loaded at enabled edge n takes `wdata` at enabled edge n+3. Lane i is `wdata[8i+7:8i]`. A lane is written only when `bsel_n[i]` was 0 at the address edge. A write with all four selects at 1 changes nothing.
- R4: `rd_oe` is 0 in the slot of every write, deselect or idle cycle.
- R5: Reads and writes may alternate on consecutive enabled edges, and each one completes with no gap cycle.
- R6: While `clk_en` is 0, a rising edge changes no state. This covers the pipeline, the burst counter and the outputs, and all other inputs are ignored.
- R7: A load (`advance`=0) is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise the cycle is a deselect, starts no operation and writes nothing.
- R8: An advance (`advance`=1) after a deselect keeps the block deselected and starts no operation.
- R9: An advance after a selected load ignores the chip selects and `wr_n`. It repeats the loaded operation type at the next burst address, using the byte selects of the advance cycle.
- R10: With `interleave`=0 at the load, the two low address bits of beat k are (start + k) mod 4, and the upper address bits stay fixed.
- R11: With `interleave`=1 at the load, the two low address bits of beat k are start XOR k.
- R12: A read loaded one enabled edge after a write to the same address returns the written lanes from that write's `wdata`, and the stored value in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| addr | input | AW | Word address for a load |
| advance | input | 1 | 0 loads a new address, 1 continues the burst |
| wr_n | input | 1 | 0 starts a write, 1 a read, on a load |
| bsel_n | input | NB | Byte-lane write selects, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| interleave | input | 1 | Burst order taken at load: 0 linear, 1 interleaved |
| wdata | input | 8*NB | Write data, taken in the write's slot |
| rdata | output | 8*NB | Registered read data |
| rd_oe | output | 1 | 1 while the block would drive read data |

## Verification
Every operation is counted in enabled edges from the edge that takes its address. Its read word and `rd_oe` are due just after the second enabled edge that follows, and its write data is due at the third. The driver records the operation kind of each enabled edge in a ring. It places write data on `wdata` three enabled edges after the address, and it queues the expected read words, taken from a reference array updated in program order. After each enabled edge, the monitor looks up the kind of operation issued two enabled edges earlier. From that it knows whether `rd_oe` must be set and whether to pop the queue. After a disabled edge, it requires both outputs to be unchanged. Stalls therefore move every due point along without any change to the checks.

// File: rtl/zt_pkg.sv
// Package: shared types for the pipelined burst SRAM model.
// Assumes: nothing beyond IEEE 1800-2017.
package zt_pkg;

    // Operation carried down the pipeline.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zt_burst_ctl.sv
// Module: zt_burst_ctl
// Decodes a load/advance cycle into one operation and its address. It keeps
// the burst state: whether a burst is live, the base address, the beat count,
// the operation type and the burst order.
// Assumes: AW > BURST_W. The operation output is combinational and is
// registered by the first pipeline stage.
module zt_burst_ctl
    import zt_pkg::*;
#(
    parameter int AW      = 6,
    parameter int NB      = 4,
    parameter int BURST_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          advance,
    input  logic          wr_n,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          interleave,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] bsel_n,
    output op_e           op,
    output logic [AW-1:0] op_addr,
    output logic [NB-1:0] op_bsel_n,
    output logic          burst_live
);

    localparam int HI_W = AW - BURST_W;

    logic               live_q;
    logic               kind_wr_q;
    logic               ilv_q;
    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;

    logic               chosen;
    logic [BURST_W-1:0] nxt_cnt;
    logic [BURST_W-1:0] low_bits;
    logic [HI_W-1:0]    hi_bits;

    assign chosen     = !sel_a_n && sel_b && !sel_c_n;
    assign nxt_cnt    = cnt_q + 1'b1;
    assign hi_bits    = base_q[AW-1:BURST_W];
    assign burst_live = live_q;
    assign op_bsel_n  = bsel_n;

    // Next burst beat address in the order chosen at load time.
    always_comb begin
        if (ilv_q) begin
            low_bits = base_q[BURST_W-1:0] ^ nxt_cnt;
        end else begin
            low_bits = base_q[BURST_W-1:0] + nxt_cnt;
        end
    end

    // Select the operation for this cycle: load, continue burst or idle.
    always_comb begin
        op      = OP_NONE;
        op_addr = addr;
        if (!advance) begin
            if (chosen) begin
                op = wr_n ? OP_READ : OP_WRITE;
            end
        end else if (live_q) begin
            op      = kind_wr_q ? OP_WRITE : OP_READ;
            op_addr = {hi_bits, low_bits};
        end
    end

    // Burst state: loaded on a load cycle, stepped on an advance, held in a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q    <= 1'b0;
            kind_wr_q <= 1'b0;
            ilv_q     <= 1'b0;
            base_q    <= '0;
            cnt_q     <= '0;
        end else if (clk_en) begin
            if (!advance) begin
                live_q    <= chosen;
                kind_wr_q <= !wr_n;
                ilv_q     <= interleave;
                base_q    <= addr;
                cnt_q     <= '0;
            end else if (live_q) begin
                cnt_q <= nxt_cnt;
            end
        end
    end

endmodule

// File: rtl/zt_stage.sv
// Module: zt_stage
// One register stage of the access pipeline. It carries the operation, the
// word address and the byte selects, and advances only on enabled edges.
// Assumes: a reset empties the stage to OP_NONE.
module zt_stage
    import zt_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  op_e           d_op,
    input  logic [AW-1:0] d_addr,
    input  logic [NB-1:0] d_bsel_n,
    output op_e           q_op,
    output logic [AW-1:0] q_addr,
    output logic [NB-1:0] q_bsel_n
);

    // Move the operation one slot forward when the clock is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op     <= OP_NONE;
            q_addr   <= '0;
            q_bsel_n <= '1;
        end else if (clk_en) begin
            q_op     <= d_op;
            q_addr   <= d_addr;
            q_bsel_n <= d_bsel_n;
        end
    end

endmodule

// File: rtl/zt_store.sv
// Module: zt_store
// The storage array. It commits the write in its data slot, lane by lane, and
// gives the word for the read about to be registered. The posted write that
// commits on the same edge is forwarded into that word.
// Assumes: the array has no reset; writes are gated by pipeline state that is
// reset.
module zt_store
    import zt_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            clk_en,
    input  logic [AW-1:0]   rd_addr,
    input  op_e             wr_op,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NB-1:0]   wr_bsel_n,
    input  logic [8*NB-1:0] wdata,
    output logic [8*NB-1:0] rd_word
);

    localparam int DW    = 8 * NB;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          wr_hit;
    logic [DW-1:0] stored;

    assign stored = mem[rd_addr];
    assign wr_hit = (wr_op == OP_WRITE) && (wr_addr == rd_addr);

    // Per-lane merge of the stored word with the write that commits now.
    always_comb begin
        rd_word = stored;
        for (int i = 0; i < NB; i++) begin
            if (wr_hit && !wr_bsel_n[i]) begin
                rd_word[8*i +: 8] = wdata[8*i +: 8];
            end
        end
    end

    // Commit the write in its data slot, on the selected lanes only.
    always_ff @(posedge clk) begin
        if (clk_en && wr_op == OP_WRITE) begin
            for (int i = 0; i < NB; i++) begin
                if (!wr_bsel_n[i]) begin
                    mem[wr_addr][8*i +: 8] <= wdata[8*i +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/zt_burst_sram.sv
// Module: zt_burst_sram (top)
// Pipelined SRAM with the same slot timing for reads and writes. An operation
// whose address is taken at enabled edge n owns the bus slot that follows
// edge n+2. A read's word is registered at n+2. A write's data is taken at
// n+3. Deasserting clk_en freezes every register.
// Assumes: synchronous active-low reset; the bidirectional bus is split
// into wdata/rdata, and rd_oe marks the slots the block would drive.
module zt_burst_sram
    import zt_pkg::*;
#(
    parameter int AW      = 6,
    parameter int NB      = 4,
    parameter int BURST_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_en,
    input  logic [AW-1:0]   addr,
    input  logic            advance,
    input  logic            wr_n,
    input  logic [NB-1:0]   bsel_n,
    input  logic            sel_a_n,
    input  logic            sel_b,
    input  logic            sel_c_n,
    input  logic            interleave,
    input  logic [8*NB-1:0] wdata,
    output logic [8*NB-1:0] rdata,
    output logic            rd_oe
);

    localparam int DW      = 8 * NB;
    localparam int NSTAGE  = 3;
    localparam int RD_STG  = NSTAGE - 1;
    localparam int WR_STG  = NSTAGE;

    op_e           op_q     [NSTAGE+1];
    logic [AW-1:0] addr_q   [NSTAGE+1];
    logic [NB-1:0] bsel_q   [NSTAGE+1];
    logic          burst_live;
    logic [DW-1:0] rd_word;

    zt_burst_ctl #(
        .AW      (AW),
        .NB      (NB),
        .BURST_W (BURST_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .advance    (advance),
        .wr_n       (wr_n),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .interleave (interleave),
        .addr       (addr),
        .bsel_n     (bsel_n),
        .op         (op_q[0]),
        .op_addr    (addr_q[0]),
        .op_bsel_n  (bsel_q[0]),
        .burst_live (burst_live)
    );

    for (genvar s = 1; s <= NSTAGE; s++) begin : g_stage
        zt_stage #(
            .AW (AW),
            .NB (NB)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .clk_en   (clk_en),
            .d_op     (op_q[s-1]),
            .d_addr   (addr_q[s-1]),
            .d_bsel_n (bsel_q[s-1]),
            .q_op     (op_q[s]),
            .q_addr   (addr_q[s]),
            .q_bsel_n (bsel_q[s])
        );
    end

    zt_store #(
        .AW (AW),
        .NB (NB)
    ) u_store (
        .clk       (clk),
        .clk_en    (clk_en),
        .rd_addr   (addr_q[RD_STG]),
        .wr_op     (op_q[WR_STG]),
        .wr_addr   (addr_q[WR_STG]),
        .wr_bsel_n (bsel_q[WR_STG]),
        .wdata     (wdata),
        .rd_word   (rd_word)
    );

    // Output register: load the read word and the drive flag for the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_oe <= 1'b0;
            rdata <= '0;
        end else if (clk_en) begin
            rd_oe <= (op_q[RD_STG] == OP_READ);
            if (op_q[RD_STG] == OP_READ) begin
                rdata <= rd_word;
            end
        end
    end

endmodule

// File: rtl/zt_burst_sram_chk.sv
// Module: zt_burst_sram_chk
// Property checker bound to zt_burst_sram. It watches ports and the internal
// stage and burst signals.
// Assumes: connected through the bind below.
module zt_burst_sram_chk
    import zt_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          advance,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          burst_live,
    input op_e           s1_op,
    input op_e           s2_op,
    input op_e           s3_op,
    input logic          rd_oe,
    input logic [DW-1:0] rdata
);

    // R1: first cycle after reset shows idle outputs
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rd_oe && rdata == '0));

    // R2: a read in the second stage drives the next slot
    a_r2_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_op == OP_READ) |=> rd_oe);

    // R4: never drive during a write slot
    a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_op == OP_WRITE) |-> !rd_oe);

    // R6: a disabled edge changes nothing visible
    a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rd_oe) && $stable(rdata) && $stable(s1_op) && $stable(s3_op)));

    // R7: an unselected load starts nothing
    a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !advance && (sel_a_n || !sel_b || sel_c_n)) |=> (s1_op == OP_NONE));

    // R8: an advance with no live burst starts nothing
    a_r8_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && advance && !burst_live) |=> (s1_op == OP_NONE));

    // R9: an advance in a live burst always issues a beat
    a_r9_burst_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && advance && burst_live) |=> (s1_op != OP_NONE));

endmodule

bind zt_burst_sram zt_burst_sram_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .advance    (advance),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .burst_live (burst_live),
    .s1_op      (op_q[1]),
    .s2_op      (op_q[2]),
    .s3_op      (op_q[3]),
    .rd_oe      (rd_oe),
    .rdata      (rdata)
);

// File: tb/sim_zt_burst_sram.sv
// Scoreboard bench: the driver issues one cycle per call, keeps a reference
// array and burst model, and queues the expected read words. The monitor
// checks the output slot after every edge.
module sim_zt_burst_sram;
    import zt_pkg::*;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 8 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          advance = 1'b0;
    logic          wr_n = 1'b1;
    logic [NB-1:0] bsel_n = '1;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          interleave = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rd_oe;

    always #5 clk = ~clk;

    zt_burst_sram #(.AW(AW), .NB(NB), .BURST_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .advance(advance),
        .wr_n(wr_n), .bsel_n(bsel_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .interleave(interleave), .wdata(wdata),
        .rdata(rdata), .rd_oe(rd_oe)
    );

    int            n_cmp = 0;
    int            n_bad = 0;
    logic [DW-1:0] model [1 << AW];
    op_e           pk_kind [16];
    logic [DW-1:0] pk_data [16];
    logic [DW-1:0] expq [$];
    string         tagq [$];
    string         cur_tag = "R2 read";
    int            ecount = 0;
    bit            last_en = 1'b0;
    bit            mon_on = 1'b0;
    logic [DW-1:0] prev_rd = '0;
    logic          prev_oe = 1'b0;

    // Bench burst model
    bit            b_live = 1'b0;
    bit            b_wr = 1'b0;
    bit            b_ilv = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            pk_kind[i] = OP_NONE;
            pk_data[i] = '0;
        end
    end

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Count enabled edges.
    always @(posedge clk) begin
        last_en <= rst_n && clk_en;
        if (rst_n && clk_en) ecount <= ecount + 1;
    end

    // Monitor: slot checks after enabled edges, hold checks after stalled ones.
    always @(negedge clk) begin
        if (mon_on) begin
            if (last_en) begin
                op_e k;
                k = pk_kind[(ecount - 2) & 15];
                check("R4 rd_oe per slot", {{(DW-1){1'b0}}, rd_oe},
                      {{(DW-1){1'b0}}, (k == OP_READ)});
                if (k == OP_READ && expq.size() > 0) begin
                    logic [DW-1:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(t, rdata, e);
                end
            end else begin
                check("R6 rdata held in stall", rdata, prev_rd);
                check("R6 rd_oe held in stall", {{(DW-1){1'b0}}, rd_oe},
                      {{(DW-1){1'b0}}, prev_oe});
            end
        end
        prev_rd = rdata;
        prev_oe = rd_oe;
    end

    // Driver: one cycle of inputs; updates the reference model on enabled cycles.
    task automatic drive(bit en, bit adv, bit wn, bit [2:0] cs, bit ilv,
                         logic [AW-1:0] a, logic [NB-1:0] bs, logic [DW-1:0] wd);
        int            k;
        op_e           kind;
        logic [AW-1:0] ea;
        @(negedge clk);
        k = ecount + 1;
        clk_en = en; advance = adv; wr_n = wn;
        {sel_a_n, sel_b, sel_c_n} = cs;
        interleave = ilv; addr = a; bsel_n = bs;
        wdata = (pk_kind[(k - 3) & 15] == OP_WRITE) ? pk_data[(k - 3) & 15] : DW'($urandom);
        if (en) begin
            kind = OP_NONE;
            ea = a;
            if (!adv) begin
                if (cs == 3'b010) begin
                    kind = wn ? OP_READ : OP_WRITE;
                    b_live = 1'b1; b_wr = !wn; b_base = a; b_cnt = '0; b_ilv = ilv;
                end else begin
                    b_live = 1'b0;
                end
            end else if (b_live) begin
                b_cnt = b_cnt + 2'd1;
                kind = b_wr ? OP_WRITE : OP_READ;
                ea = {b_base[AW-1:2], b_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            end
            if (kind == OP_WRITE) begin
                for (int i = 0; i < NB; i++) begin
                    if (!bs[i]) model[ea][8*i +: 8] = wd[8*i +: 8];
                end
                pk_data[k & 15] = wd;
            end
            if (kind == OP_READ) begin
                expq.push_back(model[ea]);
                tagq.push_back(cur_tag);
            end
            pk_kind[k & 15] = kind;
        end
    endtask

    task automatic ld(bit wn, logic [AW-1:0] a, bit ilv, logic [NB-1:0] bs);
        drive(1'b1, 1'b0, wn, 3'b010, ilv, a, bs, DW'($urandom));
    endtask

    task automatic adv(logic [NB-1:0] bs, bit [2:0] cs);
        drive(1'b1, 1'b1, 1'($urandom), cs, 1'($urandom), AW'($urandom), bs, DW'($urandom));
    endtask

    task automatic nop();
        drive(1'b1, 1'b0, 1'b1, 3'b110, 1'b0, '0, '1, '0);
    endtask

    task automatic stall();
        drive(1'b0, 1'($urandom), 1'b0, 3'b010, 1'($urandom), AW'($urandom), '0, DW'($urandom));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual still running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle right after reset
        check("R1 rd_oe after reset", {{(DW-1){1'b0}}, rd_oe}, '0);
        check("R1 rdata after reset", rdata, '0);
        mon_on = 1'b1;

        // R3/R10: fill the array with linear write bursts, every cycle busy
        for (int j = 0; j < 16; j++) begin
            ld(1'b0, AW'(4 * j), 1'b0, 4'b0000);
            for (int b = 0; b < 3; b++) adv(4'b0000, 3'b010);
        end

        // R2: single reads at scattered addresses
        cur_tag = "R2 read latency";
        ld(1'b1, 6'd0, 1'b0, '1); nop();
        ld(1'b1, 6'd37, 1'b0, '1); ld(1'b1, 6'd63, 1'b0, '1); nop(); nop();

        // R5: read/write alternation on every edge
        cur_tag = "R5 alternate";
        ld(1'b0, 6'd5, 1'b0, 4'b0000); ld(1'b1, 6'd6, 1'b0, '1);
        ld(1'b0, 6'd7, 1'b0, 4'b0000); ld(1'b1, 6'd5, 1'b0, '1);
        ld(1'b0, 6'd6, 1'b0, 4'b0000); ld(1'b1, 6'd7, 1'b0, '1);
        ld(1'b1, 6'd6, 1'b0, '1);

        // R3: partial lanes and the empty write
        cur_tag = "R3 byte lanes";
        ld(1'b0, 6'd20, 1'b0, 4'b0110); nop(); ld(1'b0, 6'd21, 1'b0, 4'b1111); nop();
        ld(1'b1, 6'd20, 1'b0, '1); ld(1'b1, 6'd21, 1'b0, '1);

        // R12: read right behind a partial write to the same word
        cur_tag = "R12 posted merge";
        ld(1'b0, 6'd10, 1'b0, 4'b1010); ld(1'b1, 6'd10, 1'b0, '1);
        ld(1'b0, 6'd11, 1'b0, 4'b0000); ld(1'b1, 6'd11, 1'b0, '1);
        nop();

        // R10: linear read burst from low bits 2 (2,3,0,1)
        cur_tag = "R10 linear order";
        ld(1'b1, 6'd14, 1'b0, '1);
        for (int b = 0; b < 3; b++) adv('1, 3'b010);
        // R11: interleaved read burst from low bits 3 (3,2,1,0) and 1 (1,0,3,2)
        cur_tag = "R11 interleaved order";
        ld(1'b1, 6'd27, 1'b1, '1);
        for (int b = 0; b < 3; b++) adv('1, 3'b010);
        ld(1'b0, 6'd41, 1'b1, 4'b0000);
        for (int b = 0; b < 3; b++) adv(4'b0000, 3'b010);
        ld(1'b1, 6'd40, 1'b0, '1);
        for (int b = 0; b < 3; b++) adv('1, 3'b010);

        // R7: deselected write attempts, each chip select in turn
        cur_tag = "R7 deselect";
        drive(1'b1, 1'b0, 1'b0, 3'b110, 1'b0, 6'd30, 4'b0000, DW'($urandom));
        drive(1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 6'd30, 4'b0000, DW'($urandom));
        drive(1'b1, 1'b0, 1'b0, 3'b011, 1'b0, 6'd30, 4'b0000, DW'($urandom));
        // R8: advances after a deselect start nothing
        drive(1'b1, 1'b1, 1'b0, 3'b010, 1'b0, 6'd30, 4'b0000, DW'($urandom));
        drive(1'b1, 1'b1, 1'b0, 3'b010, 1'b1, 6'd31, 4'b0000, DW'($urandom));
        nop(); nop();
        cur_tag = "R8 no op after deselect";
        ld(1'b1, 6'd30, 1'b0, '1); ld(1'b1, 6'd31, 1'b0, '1);

        // R9: burst continues with all chip selects off and lane selects per beat
        cur_tag = "R9 burst ignores selects";
        ld(1'b0, 6'd48, 1'b0, 4'b1110);
        adv(4'b1101, 3'b101); adv(4'b1011, 3'b000); adv(4'b0111, 3'b111);
        ld(1'b1, 6'd48, 1'b0, '1);
        adv('1, 3'b101); adv('1, 3'b101); adv('1, 3'b101);

        // R6: stalls mid-burst and over a write slot
        cur_tag = "R6 stall";
        ld(1'b1, 6'd52, 1'b1, '1); stall(); stall();
        adv('1, 3'b010); stall(); adv('1, 3'b010);
        ld(1'b0, 6'd3, 1'b0, 4'b0000); stall(); nop(); stall(); stall(); nop();
        ld(1'b1, 6'd3, 1'b0, '1); stall(); nop(); stall(); nop();

        repeat (6) nop();
        check("R2 all reads delivered", DW'(expq.size()), '0);
        finish_run();
    end

endmodule